// File: doc/BRIEF.md
# Slot-Interleaved Thread Fetch Selector

This block decides, every clock cycle, which hardware thread of an interleaved multithreaded pipeline may fetch. A free-running slot counter labels each cycle with a slot number that steps through 0 to NUM_SLOTS-1 and then wraps. Every thread belongs to exactly one slot for its whole life. Thread number `tid = slot + NUM_SLOTS * k` is the k-th member of that slot's group. Each group therefore holds NUM_THREADS/NUM_SLOTS threads. Because of this binding, a thread can only enter the pipeline once every NUM_SLOTS cycles, and consecutive instructions of one thread never sit in adjacent pipeline stages.

In each cycle the selector looks only at the ready flags of the current slot's group. A rotating pointer, one per slot, picks one ready member. The block then presents that thread's number and its 32-bit program counter. If no member of the current slot is ready, the cycle is a bubble; the slot is never lent to another group. Cache or translation misses elsewhere simply lower a thread's ready flag, so the other threads of that slot take over.

Each thread's program counter steps by 4 when the thread issues. A redirect port loads a new counter value for any thread. A global freeze holds the slot counter, the pointers and the counters, and it forces a bubble.

Top module: `tsf_fetch_sel`

## Requirements
- R1: While rst_ni is low, slot_o is 0, every thread's PC returns to BOOT_PC (default 0), and every slot pointer returns to group index 0.
- R2: In each cycle without freeze_i, slot_o advances by one, and it wraps from NUM_SLOTS-1 to 0.
- R3: When valid_o is 1, ready_i[tid_o] is 1 and tid_o mod NUM_SLOTS equals slot_o, where tid_o = slot_o + NUM_SLOTS * group_index.
- R4: Within a slot, the search starts at that slot's pointer, goes through the group indices in ascending order, and wraps. After an issue, the pointer moves to the index just past the granted one. Ready threads of one slot therefore alternate.
- R5: If no thread of the current slot's group is ready, valid_o is 0, even when threads of other slots are ready.
- R6: While freeze_i is 1, valid_o is 0, and slot_o, the slot pointers and the PCs keep their values. A redirect is the only exception: it still loads a PC.
- R7: A redirect (redir_i=1) loads redir_pc_i into the PC of thread redir_tid_i at the next edge. It takes priority over an advance of that same thread in the same cycle.
- R8: pc_o shows the PC of the selected thread. Issuing the thread adds 4 to its PC, modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| freeze_i | input | 1 | Global hold; forces a bubble |
| ready_i | input | NUM_THREADS | Per-thread ready flag, bit n = thread n |
| redir_i | input | 1 | Load a new PC for redir_tid_i |
| redir_tid_i | input | TID_W | Thread receiving the redirect |
| redir_pc_i | input | PC_W | Redirect target |
| slot_o | output | SLOT_W | Current slot ID |
| valid_o | output | 1 | A thread issues this cycle |
| tid_o | output | TID_W | Selected thread ID |
| pc_o | output | PC_W | PC of the selected thread |

## Verification
On every cycle, the assertions check several things. The slot sequence must step and wrap correctly, and it must hold under freeze. A grant must always go to a ready thread of the current slot. A bubble must occur exactly when the current group has no ready thread, or under freeze. Other behaviour needs the bench's scenarios, because it involves memory across many cycles. This covers the alternation that the rotating pointer produces, the pointer keeping its place through a freeze, the +4 step with wrap, a redirect overriding an advance, and a reset issued in the middle of a run.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int unsigned INSTR_BYTES = 4;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tsf_slot_ctr.sv
module tsf_slot_ctr
  import tsf_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  localparam int unsigned SLOT_W = idx_width(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      slot_q <= '0;
    else if (!hold_i) slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
  end

  assign slot_o = slot_q;
endmodule

// File: rtl/tsf_rr_pick.sv
module tsf_rr_pick
  import tsf_pkg::*;
#(
  parameter int unsigned WAYS = 2,
  localparam int unsigned IDX_W = idx_width(WAYS)
) (
  input  logic [IDX_W-1:0] ptr_i,
  input  logic [WAYS-1:0]  req_i,
  output logic             gnt_o,
  output logic [IDX_W-1:0] idx_o
);
  // first requester at or after ptr_i, wrapping
  always_comb begin
    gnt_o = 1'b0;
    idx_o = '0;
    for (int off = 0; off < int'(WAYS); off++) begin
      int cand;
      cand = int'(ptr_i) + off;
      if (cand >= int'(WAYS)) cand = cand - int'(WAYS);
      if (!gnt_o && req_i[IDX_W'(cand)]) begin
        gnt_o = 1'b1;
        idx_o = IDX_W'(cand);
      end
    end
  end
endmodule

// File: rtl/tsf_ptr_bank.sv
module tsf_ptr_bank
  import tsf_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned WAYS      = 2,
  localparam int unsigned SLOT_W = idx_width(NUM_SLOTS),
  localparam int unsigned IDX_W  = idx_width(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              adv_i,
  input  logic [IDX_W-1:0]  gnt_idx_i,
  output logic [IDX_W-1:0]  ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WAYS - 1);

  logic [IDX_W-1:0] ptr_q [NUM_SLOTS];
  logic [IDX_W-1:0] ptr_nxt;

  assign ptr_nxt = (gnt_idx_i == LAST) ? '0 : gnt_idx_i + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(NUM_SLOTS); s++) ptr_q[s] <= '0;
    end else if (adv_i) begin
      ptr_q[slot_i] <= ptr_nxt;
    end
  end

  assign ptr_o = ptr_q[slot_i];
endmodule

// File: rtl/tsf_pc_bank.sv
module tsf_pc_bank
  import tsf_pkg::*;
#(
  parameter int unsigned     NUM_THREADS = 16,
  parameter int unsigned     PC_W        = 32,
  parameter logic [PC_W-1:0] BOOT_PC     = '0,
  localparam int unsigned TID_W = idx_width(NUM_THREADS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [TID_W-1:0] adv_tid_i,
  input  logic             redir_i,
  input  logic [TID_W-1:0] redir_tid_i,
  input  logic [PC_W-1:0]  redir_pc_i,
  input  logic [TID_W-1:0] rd_tid_i,
  output logic [PC_W-1:0]  rd_pc_o
);
  logic [PC_W-1:0] pc_q [NUM_THREADS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < int'(NUM_THREADS); t++) pc_q[t] <= BOOT_PC;
    end else begin
      for (int t = 0; t < int'(NUM_THREADS); t++) begin
        if (redir_i && redir_tid_i == TID_W'(t))
          pc_q[t] <= redir_pc_i;
        else if (adv_i && adv_tid_i == TID_W'(t))
          pc_q[t] <= pc_q[t] + PC_W'(INSTR_BYTES);
      end
    end
  end

  assign rd_pc_o = pc_q[rd_tid_i];
endmodule

// File: rtl/tsf_fetch_sel.sv
module tsf_fetch_sel
  import tsf_pkg::*;
#(
  parameter int unsigned     NUM_SLOTS   = 8,
  parameter int unsigned     NUM_THREADS = 16,
  parameter int unsigned     PC_W        = 32,
  parameter logic [PC_W-1:0] BOOT_PC     = '0,
  localparam int unsigned WAYS   = NUM_THREADS / NUM_SLOTS,
  localparam int unsigned SLOT_W = idx_width(NUM_SLOTS),
  localparam int unsigned TID_W  = idx_width(NUM_THREADS),
  localparam int unsigned IDX_W  = idx_width(WAYS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   freeze_i,
  input  logic [NUM_THREADS-1:0] ready_i,
  input  logic                   redir_i,
  input  logic [TID_W-1:0]       redir_tid_i,
  input  logic [PC_W-1:0]        redir_pc_i,
  output logic [SLOT_W-1:0]      slot_o,
  output logic                   valid_o,
  output logic [TID_W-1:0]       tid_o,
  output logic [PC_W-1:0]        pc_o
);
  logic [SLOT_W-1:0] slot;
  logic [WAYS-1:0]   grp_req;
  logic [IDX_W-1:0]  ptr, gnt_idx;
  logic              gnt, issue;
  logic [TID_W-1:0]  tid;

  tsf_slot_ctr #(.NUM_SLOTS(NUM_SLOTS)) i_slot_ctr (
    .clk_i, .rst_ni, .hold_i(freeze_i), .slot_o(slot)
  );

  // group member k of the current slot is thread slot + NUM_SLOTS*k
  for (genvar k = 0; k < int'(WAYS); k++) begin : g_grp
    assign grp_req[k] = ready_i[TID_W'(slot) + TID_W'(NUM_SLOTS * k)];
  end

  tsf_ptr_bank #(.NUM_SLOTS(NUM_SLOTS), .WAYS(WAYS)) i_ptr_bank (
    .clk_i, .rst_ni, .slot_i(slot), .adv_i(issue), .gnt_idx_i(gnt_idx), .ptr_o(ptr)
  );

  tsf_rr_pick #(.WAYS(WAYS)) i_rr_pick (
    .ptr_i(ptr), .req_i(grp_req), .gnt_o(gnt), .idx_o(gnt_idx)
  );

  assign issue = gnt && !freeze_i;
  assign tid   = TID_W'(slot) + TID_W'(gnt_idx) * TID_W'(NUM_SLOTS);

  tsf_pc_bank #(.NUM_THREADS(NUM_THREADS), .PC_W(PC_W), .BOOT_PC(BOOT_PC)) i_pc_bank (
    .clk_i, .rst_ni,
    .adv_i(issue), .adv_tid_i(tid),
    .redir_i, .redir_tid_i, .redir_pc_i,
    .rd_tid_i(tid), .rd_pc_o(pc_o)
  );

  assign slot_o  = slot;
  assign valid_o = issue;
  assign tid_o   = tid;
endmodule

// File: rtl/tsf_fetch_sel_chk.sv
module tsf_fetch_sel_chk
  import tsf_pkg::*;
#(
  parameter int unsigned NUM_SLOTS   = 8,
  parameter int unsigned NUM_THREADS = 16,
  localparam int unsigned SLOT_W = idx_width(NUM_SLOTS),
  localparam int unsigned TID_W  = idx_width(NUM_THREADS)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   freeze_i,
  input logic [NUM_THREADS-1:0] ready_i,
  input logic [SLOT_W-1:0]      slot_o,
  input logic                   valid_o,
  input logic [TID_W-1:0]       tid_o
);
  logic grp_any;
  always_comb begin
    grp_any = 1'b0;
    for (int t = 0; t < int'(NUM_THREADS); t++)
      if ((t % int'(NUM_SLOTS)) == int'(slot_o) && ready_i[t]) grp_any = 1'b1;
  end

  // R2
  slot_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !freeze_i |=> slot_o == (($past(slot_o) == SLOT_W'(NUM_SLOTS - 1)) ? '0 : $past(slot_o) + 1'b1));
  // R6
  frz_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(slot_o));
  // R6
  frz_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |-> !valid_o);
  // R3
  gnt_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ready_i[tid_o]);
  // R3
  gnt_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (int'(tid_o) % int'(NUM_SLOTS)) == int'(slot_o));
  // R5
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grp_any |-> !valid_o);
  // R5
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_any && !freeze_i) |-> valid_o);
endmodule

bind tsf_fetch_sel tsf_fetch_sel_chk #(.NUM_SLOTS(NUM_SLOTS), .NUM_THREADS(NUM_THREADS)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .freeze_i(freeze_i), .ready_i(ready_i),
  .slot_o(slot_o), .valid_o(valid_o), .tid_o(tid_o)
);

// File: tb/test_tsf_fetch_sel.sv
module test_tsf_fetch_sel;
  localparam int C = 8;
  localparam int T = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        freeze_i = 1'b0;
  logic [15:0] ready_i = '0;
  logic        redir_i = 1'b0;
  logic [3:0]  redir_tid_i = '0;
  logic [31:0] redir_pc_i = '0;
  logic [2:0]  slot_o;
  logic        valid_o;
  logic [3:0]  tid_o;
  logic [31:0] pc_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  tsf_fetch_sel #(.NUM_SLOTS(C), .NUM_THREADS(T)) i_tsf_fetch_sel (.*);

  typedef struct packed {
    logic        frz;
    logic [15:0] rdy;
    logic [2:0]  slot;
    logic        vld;
    logic [3:0]  tid;
    logic [31:0] pc;
  } vec_t;

  // R4 alternation, R5 bubbles, R6 freeze, R8 advance
  localparam vec_t TBL [18] = '{
    '{1'b0, 16'h0101, 3'd0, 1'b1, 4'd0,  32'h0},
    '{1'b0, 16'h0200, 3'd1, 1'b1, 4'd9,  32'h0},
    '{1'b0, 16'h0000, 3'd2, 1'b0, 4'd0,  32'h0},
    '{1'b0, 16'h0008, 3'd3, 1'b1, 4'd3,  32'h0},
    '{1'b1, 16'h0010, 3'd4, 1'b0, 4'd0,  32'h0},
    '{1'b0, 16'h1010, 3'd4, 1'b1, 4'd4,  32'h0},
    '{1'b0, 16'h2002, 3'd5, 1'b1, 4'd13, 32'h0},
    '{1'b0, 16'h0080, 3'd6, 1'b0, 4'd0,  32'h0},
    '{1'b0, 16'h8080, 3'd7, 1'b1, 4'd7,  32'h0},
    '{1'b0, 16'h0101, 3'd0, 1'b1, 4'd8,  32'h0},
    '{1'b0, 16'h0202, 3'd1, 1'b1, 4'd1,  32'h0},
    '{1'b0, 16'h0000, 3'd2, 1'b0, 4'd0,  32'h0},
    '{1'b0, 16'h0008, 3'd3, 1'b1, 4'd3,  32'h4},
    '{1'b0, 16'h1010, 3'd4, 1'b1, 4'd12, 32'h0},
    '{1'b0, 16'h2020, 3'd5, 1'b1, 4'd5,  32'h0},
    '{1'b0, 16'h0001, 3'd6, 1'b0, 4'd0,  32'h0},
    '{1'b0, 16'h8080, 3'd7, 1'b1, 4'd15, 32'h0},
    '{1'b0, 16'h0101, 3'd0, 1'b1, 4'd0,  32'h4}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_slot(input int s);
    ready_i = '0; redir_i = 1'b0; freeze_i = 1'b0;
    while (int'(slot_o) != s) @(negedge clk_i);
  endtask

  task automatic fetch(input int s, input int tid, input logic [31:0] pc, input string req);
    wait_slot(s);
    ready_i = 16'(1) << tid;
    #2;
    chk(valid_o === 1'b1, req, "valid", 32'(valid_o), 32'h1);
    chk(tid_o === 4'(tid), req, "tid", 32'(tid_o), 32'(tid));
    chk(pc_o === pc, req, "pc", pc_o, pc);
    @(negedge clk_i);
    ready_i = '0; redir_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(slot_o === 3'd0, "R1", "slot in reset", 32'(slot_o), 32'h0);
    rst_ni = 1'b1;
    #2;
    chk(slot_o === 3'd0 && valid_o === 1'b0, "R1", "slot/valid after reset", 32'(slot_o), 32'h0);

    for (int i = 0; i < 18; i++) begin
      freeze_i = TBL[i].frz;
      ready_i  = TBL[i].rdy;
      #2;
      chk(slot_o === TBL[i].slot, "R2", $sformatf("slot row %0d", i), 32'(slot_o), 32'(TBL[i].slot));
      chk(valid_o === TBL[i].vld, "R5", $sformatf("valid row %0d", i), 32'(valid_o), 32'(TBL[i].vld));
      if (TBL[i].vld) begin
        chk(tid_o === TBL[i].tid, "R4", $sformatf("tid row %0d", i), 32'(tid_o), 32'(TBL[i].tid));
        chk(pc_o === TBL[i].pc, "R8", $sformatf("pc row %0d", i), pc_o, TBL[i].pc);
      end
      @(negedge clk_i);
    end
    freeze_i = 1'b0; ready_i = '0;

    // R7 redirect load
    redir_i = 1'b1; redir_tid_i = 4'd2; redir_pc_i = 32'h1000_0000;
    @(negedge clk_i);
    redir_i = 1'b0;
    fetch(2, 2, 32'h1000_0000, "R7");

    // R7 redirect beats advance in the same cycle
    wait_slot(2);
    ready_i = 16'h0004;
    redir_i = 1'b1; redir_tid_i = 4'd2; redir_pc_i = 32'h0000_2000;
    #2;
    chk(pc_o === 32'h1000_0004, "R8", "pc after advance", pc_o, 32'h1000_0004);
    @(negedge clk_i);
    redir_i = 1'b0; ready_i = '0;
    fetch(2, 2, 32'h0000_2000, "R7");

    // R8 wrap
    redir_i = 1'b1; redir_tid_i = 4'd6; redir_pc_i = 32'hFFFF_FFFC;
    @(negedge clk_i);
    redir_i = 1'b0;
    fetch(6, 6, 32'hFFFF_FFFC, "R8");
    fetch(6, 6, 32'h0000_0000, "R8");

    // R6 freeze holds slot and PC
    wait_slot(6);
    freeze_i = 1'b1; ready_i = 16'h0040;
    for (int n = 0; n < 3; n++) begin
      #2;
      chk(valid_o === 1'b0, "R6", "frozen valid", 32'(valid_o), 32'h0);
      chk(slot_o === 3'd6, "R6", "frozen slot", 32'(slot_o), 32'h6);
      @(negedge clk_i);
    end
    freeze_i = 1'b0;
    #2;
    chk(valid_o === 1'b1 && tid_o === 4'd6, "R6", "tid after freeze", 32'(tid_o), 32'h6);
    chk(pc_o === 32'h4, "R6", "pc after freeze", pc_o, 32'h4);
    @(negedge clk_i);

    // R1 reset mid-run
    ready_i = '0;
    rst_ni = 1'b0;
    #2;
    chk(slot_o === 3'd0, "R1", "slot on async reset", 32'(slot_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    ready_i = 16'h0001;
    #2;
    chk(valid_o === 1'b1 && tid_o === 4'd0, "R1", "tid after reset", 32'(tid_o), 32'h0);
    chk(pc_o === 32'h0, "R1", "pc after reset", pc_o, 32'h0);
    @(negedge clk_i);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule